// File: doc/BRIEF.md
# Epoch-Based Refresh Period Auto-Tuner

This block picks, at run time, the period that a downstream reconstitution tracker should use. It watches a stream of memory access events: one strobe per access, with the access latency and a flag that says whether the private cache hit. Time is cut into fixed epochs. For each epoch the block adds up latency, accesses and hits, and at the end of the epoch it compares the average latency with the average of the epoch before.

When the average latency moves by 5% or more, the workload is taken to have entered a new phase. The tuner then runs a sweep. Each candidate period (10, 50, 100, 500, 1000 cycles) is applied for exactly one epoch, in ascending order. The candidate whose epoch gave the best private-cache hit rate is kept. That period stays in force until the next phase shift is seen. No division is used anywhere: every ratio is compared by cross-multiplying.

Top module: `period_tuner`

## Requirements
- R1: After reset `periodOut` is 500. The first epoch is made of the first `EPOCH_CYCLES` clock cycles after reset is released. Every later epoch is the next `EPOCH_CYCLES` cycles. `periodOut` can change only on the clock edge that closes an epoch.
- R2: The first epoch after reset only records the latency baseline. It never starts a sweep, and `periodOut` stays 500 after it.
- R3: Outside a sweep, a phase shift is declared at the end of an epoch when 20 × |current average latency − previous average latency| ≥ previous average latency. This holds for a rise and for a fall. Averages are latency sum divided by accepted accesses, and are compared by cross-multiplying. A shift just under 5% declares nothing.
- R4: A cycle with `accVld` low adds nothing to the latency sum, the access count or the hit count, whatever `accLat` and `accHit` carry.
- R5: When a phase shift is declared, `periodOut` becomes 10 for the next epoch. It then steps through 50, 100, 500 and 1000, one epoch each, in that order.
- R6: While a sweep runs, latency shifts do not restart it or cut it short.
- R7: At the end of the epoch for candidate 1000, `periodOut` takes the candidate with the highest hit rate (hits divided by accepted accesses). The last candidate is included in this choice.
- R8: When two candidates have equal hit rates, the smaller period is chosen.
- R9: Outside a sweep, an epoch with no phase shift leaves `periodOut` unchanged. The epoch after a sweep is measured against the last sweep epoch's average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accVld | input | 1 | An access completed this cycle |
| accLat | input | LAT_W | Latency of the access, in cycles |
| accHit | input | 1 | The access hit in the private cache |
| periodOut | output | 11 | Period currently handed to the reconstitution tracker |

## Verification
The hardest case to reach from the ports is a sweep whose result depends on rate rather than on raw counts. This covers ties, and a last candidate that beats all the earlier ones. The stimulus steers each sweep epoch's hit pattern so that these orderings come out on purpose.

A second case is hard for a different reason. One epoch has half its cycles invalid, and the invalid cycles carry huge latencies. Its average latency matches the baseline, but its latency sum is half the baseline's sum. This separates a true average comparison from a comparison of sums, and also shows that invalid cycles are ignored. Latencies during sweeps swing by large factors, so that any phase detection left active would disturb the expected period sequence.

// File: rtl/ptune_pkg.sv
package ptune_pkg;

  localparam int NCAND = 5;
  localparam int PER_W = 11;
  localparam int IDX_W = $clog2(NCAND);
  localparam logic [IDX_W-1:0] RESET_IDX = IDX_W'(3);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NCAND - 1);

  typedef enum logic [1:0] {
    ST_WARM,
    ST_WATCH,
    ST_SWEEP
  } tunerState_t;

  typedef struct packed {
    logic loadBest;
  } ctrlStb_t;

  function automatic logic [PER_W-1:0] candPeriod(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0): candPeriod = PER_W'(10);
      IDX_W'(1): candPeriod = PER_W'(50);
      IDX_W'(2): candPeriod = PER_W'(100);
      IDX_W'(3): candPeriod = PER_W'(500);
      default:   candPeriod = PER_W'(1000);
    endcase
  endfunction

endpackage

// File: rtl/ptune_datapath.sv
module ptune_datapath
  import ptune_pkg::*;
#(
  parameter int EPOCH_CYCLES = 10000,
  parameter int LAT_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accVld,
  input  logic [LAT_W-1:0] accLat,
  input  logic             accHit,
  input  ctrlStb_t         stb,
  output logic             epochEnd,
  output logic             phaseShift,
  output logic             candBetter
);

  localparam int CNT_W = $clog2(EPOCH_CYCLES + 1);
  localparam int SUM_W = CNT_W + LAT_W;
  localparam int XL_W  = SUM_W + CNT_W;
  localparam int XD_W  = XL_W + 5;
  localparam int XH_W  = 2 * CNT_W;

  logic [CNT_W-1:0] epCnt, accSum, hitSum, accTot, hitTot;
  logic [CNT_W-1:0] baseAcc, bestAcc, bestHit;
  logic [SUM_W-1:0] latSum, latTot, baseLat;
  logic [XL_W-1:0]  curScaled, baseScaled, latDiff;

  always_comb begin
    latTot   = latSum + (accVld ? SUM_W'(accLat) : '0);
    accTot   = accSum + CNT_W'(accVld);
    hitTot   = hitSum + CNT_W'(accVld & accHit);
    epochEnd = (epCnt == CNT_W'(EPOCH_CYCLES - 1));

    // average comparison without division: Lc/Ac vs Lp/Ap
    curScaled  = XL_W'(latTot) * XL_W'(baseAcc);
    baseScaled = XL_W'(baseLat) * XL_W'(accTot);
    latDiff    = (curScaled >= baseScaled) ? curScaled - baseScaled
                                           : baseScaled - curScaled;
    phaseShift = (accTot != '0) && (baseAcc != '0) &&
                 ((XD_W'(latDiff) * XD_W'(20)) >= XD_W'(baseScaled));

    candBetter = (XH_W'(hitTot) * XH_W'(bestAcc)) > (XH_W'(bestHit) * XH_W'(accTot));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epCnt   <= '0;
      accSum  <= '0;
      hitSum  <= '0;
      latSum  <= '0;
      baseAcc <= '0;
      baseLat <= '0;
      bestAcc <= '0;
      bestHit <= '0;
    end else if (epochEnd) begin
      epCnt   <= '0;
      accSum  <= '0;
      hitSum  <= '0;
      latSum  <= '0;
      baseAcc <= accTot;
      baseLat <= latTot;
      if (stb.loadBest) begin
        bestAcc <= accTot;
        bestHit <= hitTot;
      end
    end else begin
      epCnt  <= epCnt + CNT_W'(1);
      accSum <= accTot;
      hitSum <= hitTot;
      latSum <= latTot;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    epCnt < CNT_W'(EPOCH_CYCLES));

  // R4
  idle_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!accVld && !epochEnd) |=> (accSum == $past(accSum)) && (latSum == $past(latSum))
                               && (hitSum == $past(hitSum)));

  // R7
  hit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hitSum <= accSum);

endmodule

// File: rtl/ptune_ctrl.sv
module ptune_ctrl
  import ptune_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             epochEnd,
  input  logic             phaseShift,
  input  logic             candBetter,
  output ctrlStb_t         stb,
  output logic [PER_W-1:0] periodOut
);

  tunerState_t      state;
  logic [IDX_W-1:0] candIdx, bestIdx, perIdx;
  logic             takeBest;

  always_comb begin
    takeBest     = (candIdx == '0) || candBetter;
    stb.loadBest = epochEnd && (state == ST_SWEEP) && takeBest;
    periodOut    = candPeriod(perIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_WARM;
      candIdx <= '0;
      bestIdx <= '0;
      perIdx  <= RESET_IDX;
    end else if (epochEnd) begin
      case (state)
        ST_WARM: state <= ST_WATCH;
        ST_WATCH: begin
          if (phaseShift) begin
            state   <= ST_SWEEP;
            candIdx <= '0;
            perIdx  <= '0;
          end
        end
        default: begin
          if (candIdx == LAST_IDX) begin
            state  <= ST_WATCH;
            perIdx <= takeBest ? candIdx : bestIdx;
          end else begin
            candIdx <= candIdx + IDX_W'(1);
            perIdx  <= candIdx + IDX_W'(1);
          end
          if (takeBest) bestIdx <= candIdx;
        end
      endcase
    end
  end

  // R1
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !epochEnd |=> $stable(periodOut));

  // R2
  warm_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WARM && epochEnd) |=> (state == ST_WATCH) && (periodOut == PER_W'(500)));

  // R5
  sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WATCH && epochEnd && phaseShift) |=> (periodOut == PER_W'(10)));

  // R6
  sweep_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWEEP && epochEnd && candIdx != LAST_IDX) |=> (state == ST_SWEEP));

  // R9
  watch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WATCH && epochEnd && !phaseShift) |=> $stable(periodOut));

endmodule

// File: rtl/period_tuner.sv
module period_tuner
  import ptune_pkg::*;
#(
  parameter int EPOCH_CYCLES = 10000,
  parameter int LAT_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accVld,
  input  logic [LAT_W-1:0] accLat,
  input  logic             accHit,
  output logic [PER_W-1:0] periodOut
);

  ctrlStb_t stb;
  logic     epochEnd, phaseShift, candBetter;

  ptune_datapath #(
    .EPOCH_CYCLES(EPOCH_CYCLES),
    .LAT_W       (LAT_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accVld    (accVld),
    .accLat    (accLat),
    .accHit    (accHit),
    .stb       (stb),
    .epochEnd  (epochEnd),
    .phaseShift(phaseShift),
    .candBetter(candBetter)
  );

  ptune_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .epochEnd  (epochEnd),
    .phaseShift(phaseShift),
    .candBetter(candBetter),
    .stb       (stb),
    .periodOut (periodOut)
  );

endmodule

// File: tb/period_tuner_bench.sv
`timescale 1ns/1ps
module period_tuner_bench;

  localparam int EPOCH = 100;
  localparam int LAT_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             accVld = 1'b0;
  logic [LAT_W-1:0] accLat = '0;
  logic             accHit = 1'b0;
  logic [10:0]      periodOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int    expQ[$];
  string tagQ[$];
  event  epDone;

  always #5 clk = ~clk;

  period_tuner #(.EPOCH_CYCLES(EPOCH), .LAT_W(LAT_W)) u_period_tuner (
    .clk(clk), .rst(rst), .accVld(accVld), .accLat(accLat),
    .accHit(accHit), .periodOut(periodOut)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: periodOut=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one full epoch; hits on (i%10)<hitTenths; halfVld makes odd cycles invalid with junk
  task automatic runEpoch(input int lat, input int hitTenths, input bit halfVld,
                          input int expPer, input string tag);
    for (int i = 0; i < EPOCH; i++) begin
      if (halfVld && (i % 2 == 1)) begin
        accVld = 1'b0;
        accLat = LAT_W'(4000);
        accHit = 1'b1;
      end else begin
        accVld = 1'b1;
        accLat = LAT_W'(lat);
        accHit = ((i % 10) < hitTenths);
      end
      @(negedge clk);
    end
    expQ.push_back(expPer);
    tagQ.push_back(tag);
    -> epDone;
    #0;
  endtask

  // monitor
  initial begin
    forever begin
      @(epDone);
      if (expQ.size() > 0) begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(periodOut), e, t);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(int'(periodOut), 500, "R1 reset value");
    // baseline epoch
    runEpoch(100, 5, 0, 500, "R2 first epoch only baseline");
    runEpoch(104, 5, 0, 500, "R3 4pct rise ignored");
    runEpoch(100, 5, 0, 500, "R3 under 5pct fall ignored");
    runEpoch(105, 5, 0, 10,  "R3 exact 5pct rise starts sweep R5");
    // sweep 1 with wild latencies
    runEpoch(300, 3, 0, 50,  "R5 R6 step to 50");
    runEpoch(50,  7, 0, 100, "R5 R6 step to 100");
    runEpoch(300, 7, 0, 500, "R5 R6 step to 500");
    runEpoch(50,  2, 0, 1000, "R5 R6 step to 1000");
    runEpoch(300, 6, 0, 50,  "R7 R8 tie keeps smaller 50");
    runEpoch(300, 0, 0, 50,  "R9 hold after sweep");
    runEpoch(310, 9, 0, 50,  "R9 small shift holds");
    runEpoch(200, 5, 0, 10,  "R3 large fall starts sweep");
    // sweep 2: last candidate wins
    runEpoch(900, 1, 0, 50,  "R6 step to 50");
    runEpoch(20,  1, 0, 100, "R6 step to 100");
    runEpoch(900, 1, 0, 500, "R6 step to 500");
    runEpoch(20,  1, 0, 1000, "R6 step to 1000");
    runEpoch(200, 9, 0, 1000, "R7 last candidate chosen");
    runEpoch(200, 2, 1, 1000, "R4 R3 same average half valid");
    runEpoch(190, 5, 0, 10,  "R3 exact 5pct fall starts sweep");
    // sweep 3: all tie
    runEpoch(190, 0, 0, 50,  "R5 step to 50");
    runEpoch(190, 0, 0, 100, "R5 step to 100");
    runEpoch(190, 0, 0, 500, "R5 step to 500");
    runEpoch(190, 0, 0, 1000, "R5 step to 1000");
    runEpoch(190, 0, 0, 10,  "R8 all tie picks 10");
    runEpoch(190, 4, 0, 10,  "R9 hold final");
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule